// File: doc/BRIEF.md
# Zero-Suppressed Quasi-Random Bit Source and Checker

This block produces a bit-serial test pattern for a DS1 line from a 20-stage maximal-length shift register. The register's last stage gives the raw bit. A suppression rule then forces a 1 whenever the fourteen stages behind it are all clear, so the line never carries more than fourteen zeros in a row. The register advances once per bit-enable strobe. Software-free seeding is available through a load strobe.

With the checker mode input raised, the same register becomes a receiver. It first copies twenty strobed received bits into itself to synchronise. After that it generates locally and compares each received bit, delayed by twenty strobes, against the zero-suppressed local bit. Mismatches go into a saturating counter. Each 64-compare block that holds a seventh mismatch raises a one-cycle loss-of-sync pulse and restarts synchronisation.

Top module: `qrss_gen`

## Requirements
- R1: After synchronous reset every stage holds 1, so txBit is 1, errCount is 0, and locked and syncLost are 0.
- R2: In generator mode each strobe (bitEn high) shifts stage k into stage k+1 and loads stage 1 with stage 17 XOR stage 20. The raw bit is stage 20. txBit follows the register with no added delay, so in raw-bit terms x(n+20) = x(n+3) XOR x(n).
- R3: txBit equals stage 20 OR the NOR of stages 19 down to 6. No more than 14 consecutive zeros appear on txBit.
- R4: A cycle with bitEn low and seedLoad low leaves the register unchanged. txBit therefore holds whatever rxBit does, and rxBit has no effect in generator mode.
- R5: In generator mode seedLoad loads seedVal bit k-1 into stage k and takes priority over bitEn in the same cycle. An all-zero seedVal loads all ones instead.
- R6: Raising chkMode moves the block to acquisition at the next edge. The next 20 strobes shift rxBit into stage 1, and locked rises at the edge of the 20th of them.
- R7: While locked, each strobe compares txBit with the rxBit value received 20 strobes earlier and then advances the generator as in R2. A mismatch raises errCount by one at that edge.
- R8: errCount saturates at its all-ones value and never decreases except at reset.
- R9: Compares after lock are grouped into blocks of 64. The 7th mismatch inside one block gives a one-cycle syncLost pulse, drops locked and restarts acquisition. Six mismatches in a block do not.
- R10: Lowering chkMode returns the block to generator mode at the next edge with locked low and errCount held. Strobes then do no comparing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Bit strobe; advances the register |
| chkMode | input | 1 | 1 selects checker (receive) mode |
| seedLoad | input | 1 | Load seedVal into the register (generator mode) |
| seedVal | input | STAGES | Seed, bit k-1 goes to stage k |
| rxBit | input | 1 | Received bit, sampled on strobes in checker mode |
| txBit | output | 1 | Zero-suppressed pattern bit |
| errCount | output | ERR_W | Saturating mismatch count |
| locked | output | 1 | Checker synchronised and comparing |
| syncLost | output | 1 | One-cycle pulse on loss of sync |

## Verification
txBit depends only on the register, so it takes its new value at the same edge as the strobe. The bench therefore samples one nanosecond after each edge and checks it against a raw sequence worked out from the recurrence and the suppression rule. A corrupted received bit reaches errCount twenty strobes after it enters, at the edge of its compare. The bench keeps a count of compares since lock and expects each increment, and the syncLost pulse, in exactly that cycle. locked is checked at the edge of the twentieth acquisition strobe, and mode changes are checked one edge after chkMode moves.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

  typedef enum logic [1:0] {
    ST_GEN   = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRACK = 2'd2
  } qrssState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic seedLoad;
    logic genShift;
    logic rxShift;
    logic compare;
  } qrssCtl_t;

endpackage

// File: rtl/qrss_datapath.sv
module qrss_datapath
  import qrss_pkg::*;
#(
  parameter int STAGES = 20,
  parameter int TAP    = 17,
  parameter int ZRUN   = 14,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  qrssCtl_t          ctl,
  input  logic [STAGES-1:0] seedVal,
  input  logic              rxBit,
  output logic              txBit,
  output logic              mismatch,
  output logic [ERR_W-1:0]  errCount
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam int ZC_W = $clog2(ZRUN + 2);
  localparam logic [ZC_W-1:0] ZC_LIMIT = ZC_W'(ZRUN);

  logic [STAGES:1] shiftReg;
  logic [STAGES:1] rxDelay;
  logic            feedback;
  logic            zeroWindow;

  assign feedback   = shiftReg[TAP] ^ shiftReg[STAGES];
  assign zeroWindow = ~|shiftReg[STAGES-1:STAGES-ZRUN];
  assign txBit      = shiftReg[STAGES] | zeroWindow;
  assign mismatch   = txBit ^ rxDelay[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
    end else if (ctl.seedLoad) begin
      shiftReg <= (seedVal == '0) ? '1 : seedVal;
    end else if (ctl.genShift) begin
      shiftReg <= {shiftReg[STAGES-1:1], feedback};
    end else if (ctl.rxShift) begin
      shiftReg <= {shiftReg[STAGES-1:1], rxBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxDelay <= '0;
    end else if (ctl.rxShift || ctl.compare) begin
      rxDelay <= {rxDelay[STAGES-1:1], rxBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errCount <= '0;
    end else if (ctl.compare && mismatch && (errCount != ERR_MAX)) begin
      errCount <= errCount + 1'b1;
    end
  end

  // checker-side run counter of zero bits shifted out
  logic [ZC_W-1:0] zeroCnt;
  always_ff @(posedge clk) begin
    if (rst || ctl.seedLoad) begin
      zeroCnt <= '0;
    end else if (ctl.genShift || ctl.rxShift) begin
      zeroCnt <= txBit ? '0 : zeroCnt + 1'b1;
    end
  end

  assert_zero_run_R3: assert property (@(posedge clk) disable iff (rst)
    zeroCnt <= ZC_LIMIT);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(ctl.genShift || ctl.rxShift || ctl.seedLoad) |=> $stable(txBit));

  assert_seed_top_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.seedLoad |=> shiftReg[STAGES] ==
      (($past(seedVal) == '0) ? 1'b1 : $past(seedVal[STAGES-1])));

  assert_err_step_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.compare && mismatch && errCount != ERR_MAX) |=>
      errCount == $past(errCount) + 1'b1);

  assert_no_decrease_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (errCount - $past(errCount)) <= 1);

endmodule

// File: rtl/qrss_control.sv
module qrss_control
  import qrss_pkg::*;
#(
  parameter int STAGES    = 20,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitEn,
  input  logic     chkMode,
  input  logic     seedLoadIn,
  input  logic     mismatch,
  output qrssCtl_t ctl,
  output logic     locked,
  output logic     syncLost
);

  localparam int ACQ_W  = $clog2(STAGES);
  localparam int WIN_W  = $clog2(WIN);
  localparam int WERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [ACQ_W-1:0]  ACQ_LAST = ACQ_W'(STAGES - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [WERR_W-1:0] ERR_LIM  = WERR_W'(ERR_LIMIT);

  qrssState_e        state;
  logic [ACQ_W-1:0]  acqCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [WERR_W-1:0] winErr;

  always_comb begin
    ctl.seedLoad = (state == ST_GEN) && seedLoadIn;
    ctl.genShift = bitEn && (((state == ST_GEN) && !seedLoadIn) || (state == ST_TRACK));
    ctl.rxShift  = bitEn && (state == ST_ACQ);
    ctl.compare  = bitEn && (state == ST_TRACK);
  end

  assign locked = (state == ST_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_GEN;
      acqCnt   <= '0;
      winCnt   <= '0;
      winErr   <= '0;
      syncLost <= 1'b0;
    end else begin
      syncLost <= 1'b0;
      if (!chkMode) begin
        state <= ST_GEN;
      end else begin
        unique case (state)
          ST_GEN: begin
            state  <= ST_ACQ;
            acqCnt <= '0;
          end
          ST_ACQ: begin
            if (bitEn) begin
              if (acqCnt == ACQ_LAST) begin
                state  <= ST_TRACK;
                winCnt <= '0;
                winErr <= '0;
              end else begin
                acqCnt <= acqCnt + 1'b1;
              end
            end
          end
          ST_TRACK: begin
            if (bitEn) begin
              if (mismatch && (winErr == ERR_LIM)) begin
                syncLost <= 1'b1;
                state    <= ST_ACQ;
                acqCnt   <= '0;
              end else if (winCnt == WIN_LAST) begin
                winCnt <= '0;
                winErr <= '0;
              end else begin
                winCnt <= winCnt + 1'b1;
                winErr <= winErr + WERR_W'(mismatch);
              end
            end
          end
          default: state <= ST_GEN;
        endcase
      end
    end
  end

  assert_lock_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(bitEn) && $past(chkMode));

  assert_lost_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    syncLost |=> !syncLost);

  assert_lost_unlocks_R9: assert property (@(posedge clk) disable iff (rst)
    syncLost |-> !locked);

  assert_mode_exit_R10: assert property (@(posedge clk) disable iff (rst)
    !chkMode |=> !locked);

endmodule

// File: rtl/qrss_gen.sv
module qrss_gen
  import qrss_pkg::*;
#(
  parameter int STAGES    = 20,
  parameter int TAP       = 17,
  parameter int ZRUN      = 14,
  parameter int ERR_W     = 16,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              chkMode,
  input  logic              seedLoad,
  input  logic [STAGES-1:0] seedVal,
  input  logic              rxBit,
  output logic              txBit,
  output logic [ERR_W-1:0]  errCount,
  output logic              locked,
  output logic              syncLost
);

  qrssCtl_t ctl;
  logic     mismatch;

  qrss_control #(
    .STAGES(STAGES), .WIN(WIN), .ERR_LIMIT(ERR_LIMIT)
  ) control_i (
    .clk(clk), .rst(rst), .bitEn(bitEn), .chkMode(chkMode),
    .seedLoadIn(seedLoad), .mismatch(mismatch), .ctl(ctl),
    .locked(locked), .syncLost(syncLost)
  );

  qrss_datapath #(
    .STAGES(STAGES), .TAP(TAP), .ZRUN(ZRUN), .ERR_W(ERR_W)
  ) datapath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .seedVal(seedVal), .rxBit(rxBit),
    .txBit(txBit), .mismatch(mismatch), .errCount(errCount)
  );

endmodule

// File: tb/qrss_gen_tb.sv
module qrss_gen_tb_top;

  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bitEn = 1'b0;
  logic          chkMode = 1'b0;
  logic          seedLoad = 1'b0;
  logic [19:0]   seedVal = '0;
  logic          rxBit = 1'b0;
  logic          txBit;
  logic [EW-1:0] errCount;
  logic          locked;
  logic          syncLost;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qrss_gen #(.ERR_W(EW)) dut_i (
    .clk(clk), .rst(rst), .bitEn(bitEn), .chkMode(chkMode),
    .seedLoad(seedLoad), .seedVal(seedVal), .rxBit(rxBit),
    .txBit(txBit), .errCount(errCount), .locked(locked), .syncLost(syncLost)
  );

  logic xs [0:3200];   // raw sequence for the current generator seed
  logic ys [0:400];    // raw sequence from the all-ones seed (stream source)

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // raw bit i is stage 20 after i strobes; seed bit k-1 is stage k
  task automatic fillRaw(input logic [19:0] v);
    for (int i = 0; i < 20; i++) xs[i] = v[19-i];
    for (int i = 20; i <= 3200; i++) xs[i] = xs[i-20] ^ xs[i-17];
  endtask

  function automatic logic supX(input int t);
    logic anyOne = 1'b0;
    for (int k = 1; k <= 14; k++) anyOne |= xs[t+k];
    return xs[t] | ~anyOne;
  endfunction

  function automatic logic supY(input int t);
    logic anyOne = 1'b0;
    for (int k = 1; k <= 14; k++) anyOne |= ys[t+k];
    return ys[t] | ~anyOne;
  endfunction

  // inputs change and outputs are sampled 1 ns after each rising edge
  task automatic tick(input logic en, input logic rx);
    bitEn = en;
    rxBit = rx;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int t;
    int run;
    int maxRun;
    int j;
    int expErr;
    logic prevTx;

    for (int i = 0; i < 20; i++) ys[i] = 1'b1;
    for (int i = 20; i <= 400; i++) ys[i] = ys[i-20] ^ ys[i-17];

    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1 reset state
    check(txBit == 1'b1, "R1 txBit", txBit, 1);
    check(errCount == 0, "R1 errCount", errCount, 0);
    check(locked == 1'b0, "R1 locked", locked, 0);
    check(syncLost == 1'b0, "R1 syncLost", syncLost, 0);

    // R2/R3/R4 long sweep from the all-ones state, idle cycles interleaved
    fillRaw(20'hFFFFF);
    t = 0;
    run = 0;
    maxRun = 0;
    for (int s = 0; s < 3000; s++) begin
      if (s % 5 == 4) begin
        prevTx = txBit;
        tick(1'b0, s[0]);
        check(txBit == prevTx, "R4 hold on idle", txBit, prevTx);
      end else begin
        tick(1'b1, s[1]);
        t++;
        check(txBit == supX(t), "R2 sequence", txBit, supX(t));
        run = txBit ? 0 : run + 1;
        if (run > maxRun) maxRun = run;
      end
    end
    check(maxRun <= 14, "R3 zero run", maxRun, 14);

    // R5 seed with one bit in stage 1: forced ones while stage 20 is 0
    seedVal = 20'h00001;
    seedLoad = 1'b1;
    tick(1'b1, 1'b0);   // seed wins over the strobe
    seedLoad = 1'b0;
    fillRaw(20'h00001);
    check(txBit == 1'b1, "R3 forced one after seed", txBit, 1);
    run = 0;
    maxRun = 0;
    for (int s = 1; s <= 400; s++) begin
      tick(1'b1, 1'b0);
      check(txBit == supX(s), "R5 seeded sequence", txBit, supX(s));
      run = txBit ? 0 : run + 1;
      if (run > maxRun) maxRun = run;
    end
    check(maxRun <= 14, "R3 zero run seeded", maxRun, 14);

    // R5 seed with one bit in stage 6: no forcing, txBit 0
    seedVal = 20'h00020;
    seedLoad = 1'b1;
    tick(1'b0, 1'b0);
    seedLoad = 1'b0;
    check(txBit == 1'b0, "R5 unforced zero", txBit, 0);

    // R5 all-zero seed behaves as all ones
    seedVal = 20'h00000;
    seedLoad = 1'b1;
    tick(1'b0, 1'b0);
    seedLoad = 1'b0;
    fillRaw(20'hFFFFF);
    for (int s = 1; s <= 60; s++) begin
      tick(1'b1, 1'b0);
      check(txBit == supX(s), "R5 zero seed", txBit, supX(s));
    end

    // R6 enter checker mode and acquire from the start of the stream
    chkMode = 1'b1;
    tick(1'b0, 1'b0);
    check(locked == 1'b0, "R6 acquiring", locked, 0);
    for (int i = 0; i < 20; i++) begin
      tick(1'b1, supY(i));
      check(locked == (i == 19), "R6 lock timing", locked, (i == 19));
    end

    // R7/R9 tracking with injected errors at compare indices
    expErr = 0;
    for (j = 0; j <= 136; j++) begin
      logic flip;
      flip = (j == 30) || (j == 45) || (j >= 64 && j <= 69) || (j >= 130 && j <= 136);
      if (j + 20 == 30 || j + 20 == 45 || (j + 20 >= 64 && j + 20 <= 69) ||
          (j + 20 >= 130 && j + 20 <= 136))
        tick(1'b1, ~supY(j + 20));
      else
        tick(1'b1, supY(j + 20));
      if (flip && expErr < 15) expErr++;
      check(errCount == expErr, "R7 error count", errCount, expErr);
      check(syncLost == (j == 136), "R9 sync loss pulse", syncLost, (j == 136));
      check(locked == (j != 136), "R9 locked", locked, (j != 136));
    end
    check(errCount == 15, "R8 reached max", errCount, 15);
    tick(1'b0, 1'b0);
    check(syncLost == 1'b0, "R9 pulse one cycle", syncLost, 0);

    // re-acquire, then an error at the saturated count
    for (int i = 0; i < 20; i++) tick(1'b1, supY(i));
    check(locked == 1'b1, "R9 relock", locked, 1);
    for (int k = 0; k <= 30; k++) begin
      if (k + 20 == 25) tick(1'b1, ~supY(k + 20));
      else tick(1'b1, supY(k + 20));
      check(errCount == 15, "R8 saturation", errCount, 15);
    end

    // R10 back to generator mode
    chkMode = 1'b0;
    tick(1'b0, 1'b0);
    check(locked == 1'b0, "R10 unlocked", locked, 0);
    for (int k = 0; k < 8; k++) begin
      tick(1'b1, k[0]);
      check(errCount == 15, "R10 count held", errCount, 15);
      check(locked == 1'b0, "R10 stays generator", locked, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule